// File: doc/BRIEF.md
# Word DMA Transfer Engine

This block moves 16-bit words between a word-addressed disk store and byte-addressed system memory, one word at a time. There are three functions: copy disk to memory, copy memory to disk, and compare disk against memory without writing anything. A start pulse loads an 18-bit memory byte address, a 22-bit disk word address and a word count that counts upward. Both addresses are built from a 16-bit base and a narrow extension field. The engine then runs a word loop until the count reaches zero or an error stops it.

Before each word the engine checks the disk address against the configured capacity, and on a write it also checks a 32-bit per-segment lock mask. During the word it takes the not-present flag from the memory response, and on a compare it tests the two words for equality. Any of these conditions stops the loop on the failing word and sets that word's error flag. The last word moved is kept in a data buffer. Words can run back to back (burst), or be spaced by a programmable number of idle cycles. The current addresses and the count are always presented split back into base and extension fields, for the status block that sits beside the engine.

Top module: `dma_word_engine`

## Requirements
- R1: After reset, done is 1, busy is 0, all error flags are 0, the count and address outputs are 0, and no memory or disk request is driven.
- R2: start is taken only while done is 1 and func is nonzero (func encoding: 1 = memory to disk, 2 = disk to memory, 3 = compare). Taking it clears done and all error flags. A start pulse with func 0, or one that arrives while busy, changes nothing.
- R3: The memory byte address is {init_mx, init_ma} with bit 0 forced to 0, and the disk address is {init_dx, init_da}. Each word adds 1 to the disk address, adds 2 to the memory address (unless ma_hold is 1, which leaves it unchanged) and adds 1 to the count. Carries run from each base into its extension output. The transfer ends with done when the count reaches 0.
- R4: Disk-to-memory (func 2) reads the disk word at the disk address and writes it to memory at the memory address. The word also goes to dbuf.
- R5: Memory-to-disk (func 1) reads memory and writes the word to disk, and into dbuf. If bit dsk_addr[19:15] of lock_mask is set, the transfer raises err_lock before that word, with no memory or disk access for it.
- R6: Compare (func 3) reads both words, and dbuf takes the disk word. If they differ, err_cmp is raised and the transfer stops. If they match, nothing is written anywhere.
- R7: A memory response with mem_nxm = 1 raises err_nomem and stops the transfer.
- R8: A disk address at or above (plat_sel+1)*262144 raises err_nodisk before any access for that word.
- R9: With burst = 1, a memory-to-disk word takes 3 cycles and the other functions take 4, when memory acks one cycle after the request. With burst = 0, max(gap_len,1) idle cycles separate consecutive words.
- R10: On any error, done is set, exactly one error flag is raised and any_err is 1. The address and count outputs still hold the failing word's values, not stepped.
- R11: mem_req stays high until mem_ack, with mem_addr and mem_wdata held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| func | input | 2 | Function: 1 write to disk, 2 read from disk, 3 compare |
| burst | input | 1 | 1 = back-to-back words |
| gap_len | input | 16 | Idle cycles between words when not in burst |
| plat_sel | input | 3 | Number of platters minus one |
| lock_mask | input | 32 | Per-segment write lock |
| ma_hold | input | 1 | Keep the memory address fixed |
| init_ma | input | 16 | Memory address base at start |
| init_mx | input | 2 | Memory address extension at start |
| init_da | input | 16 | Disk address base at start |
| init_dx | input | 6 | Disk address extension at start |
| init_wc | input | 16 | Negative word count at start |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory response |
| mem_nxm | input | 1 | Memory not present, valid with mem_ack |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| dsk_rd | output | 1 | Disk read; data one cycle later |
| dsk_we | output | 1 | Disk write |
| dsk_addr | output | 22 | Disk word address |
| dsk_wdata | output | 16 | Disk write data |
| dsk_rdata | input | 16 | Disk read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Idle, last transfer ended |
| err_lock | output | 1 | Segment locked |
| err_cmp | output | 1 | Compare mismatch |
| err_nodisk | output | 1 | Disk address beyond capacity |
| err_nomem | output | 1 | Memory not present |
| any_err | output | 1 | OR of error flags |
| dbuf | output | 16 | Last word moved |
| cur_ma | output | 16 | Memory address base |
| cur_mx | output | 2 | Memory address extension |
| cur_da | output | 16 | Disk address base |
| cur_dx | output | 6 | Disk address extension |
| cur_wc | output | 16 | Word count |

## Verification
A wrong step in the address or count registers shows up on the very next word's mem_addr or dsk_addr, which the scoreboard compares against the reference sequence, and again in the split outputs once done rises. A stop decision taken in the wrong state shows up as an extra or a missing transaction, or as outputs stepped one word too far after an error. A mistimed state sequence changes the number of busy cycles, which the bench measures exactly for burst and for spaced runs. A wrong carry into an extension field is visible only when a base wraps, so one transfer crosses both boundaries.

// File: rtl/dwe_pkg.sv
package dwe_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_DGET  = 3'd2,
        ST_MEM   = 3'd3,
        ST_GAP   = 3'd4
    } dwe_state_e;

    typedef enum logic [1:0] {
        FN_NONE  = 2'd0,
        FN_WRITE = 2'd1,
        FN_READ  = 2'd2,
        FN_WCHK  = 2'd3
    } dwe_func_e;
endpackage

// File: rtl/dwe_range_check.sv
module dwe_range_check #(
    parameter int DAW       = 22,
    parameter int PSELW     = 3,
    parameter int PLAT_LOG2 = 18,
    parameter int SEG_LSB   = 15,
    parameter int SEGW      = 5
) (
    input  logic [DAW-1:0]         da,
    input  logic [PSELW-1:0]       plat_sel,
    input  logic [(1<<SEGW)-1:0]   lock_mask,
    output logic                   over_cap,
    output logic                   locked
);
    localparam int CW = DAW + 1;

    logic [CW-1:0] cap;

    always_comb begin
        cap      = (CW'(plat_sel) + CW'(1)) << PLAT_LOG2;
        over_cap = ({1'b0, da} >= cap);
        locked   = lock_mask[da[SEG_LSB +: SEGW]];
    end
endmodule

// File: rtl/dwe_addr_step.sv
module dwe_addr_step #(
    parameter int MAW = 18,
    parameter int DAW = 22,
    parameter int WCW = 16
) (
    input  logic [MAW-1:0] ma_i,
    input  logic [DAW-1:0] da_i,
    input  logic [WCW-1:0] wc_i,
    input  logic           hold,
    output logic [MAW-1:0] ma_o,
    output logic [DAW-1:0] da_o,
    output logic [WCW-1:0] wc_o,
    output logic           last_o
);
    always_comb begin
        ma_o   = hold ? ma_i : ma_i + MAW'(2);
        da_o   = da_i + DAW'(1);
        wc_o   = wc_i + WCW'(1);
        last_o = (wc_o == '0);
    end
endmodule

// File: rtl/dwe_pacer.sv
module dwe_pacer #(
    parameter int GAPW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [GAPW-1:0] len,
    output logic            expired
);
    logic [GAPW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = (len == '0) ? '0 : len - GAPW'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - GAPW'(1);
        expired = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    pace_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - GAPW'(1)));
endmodule

// File: rtl/dma_word_engine.sv
module dma_word_engine
    import dwe_pkg::*;
#(
    parameter int DW        = 16,
    parameter int MXW       = 2,
    parameter int DXW       = 6,
    parameter int SEG_LSB   = 15,
    parameter int SEGW      = 5,
    parameter int PLAT_LOG2 = 18,
    parameter int PSELW     = 3,
    parameter int GAPW      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             func,
    input  logic                   burst,
    input  logic [GAPW-1:0]        gap_len,
    input  logic [PSELW-1:0]       plat_sel,
    input  logic [(1<<SEGW)-1:0]   lock_mask,
    input  logic                   ma_hold,
    input  logic [DW-1:0]          init_ma,
    input  logic [MXW-1:0]         init_mx,
    input  logic [DW-1:0]          init_da,
    input  logic [DXW-1:0]         init_dx,
    input  logic [DW-1:0]          init_wc,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [DW+MXW-1:0]      mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic                   mem_ack,
    input  logic                   mem_nxm,
    input  logic [DW-1:0]          mem_rdata,
    output logic                   dsk_rd,
    output logic                   dsk_we,
    output logic [DW+DXW-1:0]      dsk_addr,
    output logic [DW-1:0]          dsk_wdata,
    input  logic [DW-1:0]          dsk_rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   err_lock,
    output logic                   err_cmp,
    output logic                   err_nodisk,
    output logic                   err_nomem,
    output logic                   any_err,
    output logic [DW-1:0]          dbuf,
    output logic [DW-1:0]          cur_ma,
    output logic [MXW-1:0]         cur_mx,
    output logic [DW-1:0]          cur_da,
    output logic [DXW-1:0]         cur_dx,
    output logic [DW-1:0]          cur_wc
);
    localparam int MAW = DW + MXW;
    localparam int DAW = DW + DXW;
    localparam int WCW = DW;

    typedef struct packed {
        dwe_state_e     st;
        dwe_func_e      fn;
        logic [MAW-1:0] ma;
        logic [DAW-1:0] da;
        logic [WCW-1:0] wc;
        logic [DW-1:0]  dbr;
        logic           done;
        logic           e_lock;
        logic           e_cmp;
        logic           e_ned;
        logic           e_nxm;
    } regs_t;

    regs_t r_d, r_q;

    logic           over_cap, seg_locked;
    logic [MAW-1:0] ma_nx;
    logic [DAW-1:0] da_nx;
    logic [WCW-1:0] wc_nx;
    logic           wc_last;
    logic           pace_load, pace_done;

    dwe_range_check #(
        .DAW(DAW), .PSELW(PSELW), .PLAT_LOG2(PLAT_LOG2),
        .SEG_LSB(SEG_LSB), .SEGW(SEGW)
    ) u_range (
        .da        (r_q.da),
        .plat_sel  (plat_sel),
        .lock_mask (lock_mask),
        .over_cap  (over_cap),
        .locked    (seg_locked)
    );

    dwe_addr_step #(.MAW(MAW), .DAW(DAW), .WCW(WCW)) u_step (
        .ma_i   (r_q.ma),
        .da_i   (r_q.da),
        .wc_i   (r_q.wc),
        .hold   (ma_hold),
        .ma_o   (ma_nx),
        .da_o   (da_nx),
        .wc_o   (wc_nx),
        .last_o (wc_last)
    );

    dwe_pacer #(.GAPW(GAPW)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pace_load),
        .len     (gap_len),
        .expired (pace_done)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        dsk_rd    = 1'b0;
        dsk_we    = 1'b0;
        pace_load = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start && func != 2'd0) begin
                    r_d.fn     = dwe_func_e'(func);
                    r_d.ma     = {init_mx, init_ma} & ~MAW'(1);
                    r_d.da     = {init_dx, init_da};
                    r_d.wc     = init_wc;
                    r_d.done   = 1'b0;
                    r_d.e_lock = 1'b0;
                    r_d.e_cmp  = 1'b0;
                    r_d.e_ned  = 1'b0;
                    r_d.e_nxm  = 1'b0;
                    r_d.st     = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (over_cap) begin
                    r_d.e_ned = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end else if (r_q.fn == FN_WRITE && seg_locked) begin
                    r_d.e_lock = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.st     = ST_IDLE;
                end else if (r_q.fn == FN_WRITE) begin
                    r_d.st = ST_MEM;
                end else begin
                    dsk_rd = 1'b1;
                    r_d.st = ST_DGET;
                end
            end
            ST_DGET: begin
                r_d.dbr = dsk_rdata;
                r_d.st  = ST_MEM;
            end
            ST_MEM: begin
                mem_req = 1'b1;
                mem_we  = (r_q.fn == FN_READ);
                if (mem_ack) begin
                    if (mem_nxm) begin
                        r_d.e_nxm = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else if (r_q.fn == FN_WCHK && mem_rdata != r_q.dbr) begin
                        r_d.e_cmp = 1'b1;
                        r_d.done  = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else begin
                        if (r_q.fn == FN_WRITE) begin
                            dsk_we  = 1'b1;
                            r_d.dbr = mem_rdata;
                        end
                        r_d.ma = ma_nx;
                        r_d.da = da_nx;
                        r_d.wc = wc_nx;
                        if (wc_last) begin
                            r_d.done = 1'b1;
                            r_d.st   = ST_IDLE;
                        end else if (burst) begin
                            r_d.st = ST_CHECK;
                        end else begin
                            pace_load = 1'b1;
                            r_d.st    = ST_GAP;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (pace_done) r_d.st = ST_CHECK;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.fn   <= FN_NONE;
            r_q.done <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_addr   = r_q.ma;
        mem_wdata  = r_q.dbr;
        dsk_addr   = r_q.da;
        dsk_wdata  = mem_rdata;
        busy       = (r_q.st != ST_IDLE);
        done       = r_q.done;
        err_lock   = r_q.e_lock;
        err_cmp    = r_q.e_cmp;
        err_nodisk = r_q.e_ned;
        err_nomem  = r_q.e_nxm;
        any_err    = r_q.e_lock | r_q.e_cmp | r_q.e_ned | r_q.e_nxm;
        dbuf       = r_q.dbr;
        cur_ma     = r_q.ma[DW-1:0];
        cur_mx     = r_q.ma[MAW-1:DW];
        cur_da     = r_q.da[DW-1:0];
        cur_dx     = r_q.da[DAW-1:DW];
        cur_wc     = r_q.wc;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R5
    lock_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_we |-> !lock_mask[dsk_addr[SEG_LSB +: SEGW]]);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_req && !dsk_rd && !dsk_we && !busy));

    // R3
    wc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cur_wc == $past(cur_wc) || cur_wc == WCW'($past(cur_wc) + WCW'(1))));

    // R10
    one_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_lock, err_cmp, err_nodisk, err_nomem}));

    // R8
    cap_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || dsk_rd || dsk_we) |-> (32'(dsk_addr[DAW-1:PLAT_LOG2]) <= 32'(plat_sel)));
endmodule

// File: tb/dma_word_engine_test.sv
`timescale 1ns/100ps
module dma_word_engine_test;
    localparam logic [17:0] NXM_LIM = 18'h20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  func = 2'd0;
    logic        burst = 1'b1;
    logic [15:0] gap_len = 16'd0;
    logic [2:0]  plat_sel = 3'd0;
    logic [31:0] lock_mask = 32'd0;
    logic        ma_hold = 1'b0;
    logic [15:0] init_ma = 16'd0, init_da = 16'd0, init_wc = 16'd0;
    logic [1:0]  init_mx = 2'd0;
    logic [5:0]  init_dx = 6'd0;
    logic        mem_req, mem_we, mem_ack, mem_nxm;
    logic [17:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        dsk_rd, dsk_we;
    logic [21:0] dsk_addr;
    logic [15:0] dsk_wdata, dsk_rdata;
    logic        busy, done, err_lock, err_cmp, err_nodisk, err_nomem, any_err;
    logic [15:0] dbuf, cur_ma, cur_da, cur_wc;
    logic [1:0]  cur_mx;
    logic [5:0]  cur_dx;

    always #2.5 clk = ~clk;

    dma_word_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func), .burst(burst),
        .gap_len(gap_len), .plat_sel(plat_sel), .lock_mask(lock_mask),
        .ma_hold(ma_hold), .init_ma(init_ma), .init_mx(init_mx),
        .init_da(init_da), .init_dx(init_dx), .init_wc(init_wc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_nxm(mem_nxm),
        .mem_rdata(mem_rdata), .dsk_rd(dsk_rd), .dsk_we(dsk_we),
        .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
        .busy(busy), .done(done), .err_lock(err_lock), .err_cmp(err_cmp),
        .err_nodisk(err_nodisk), .err_nomem(err_nomem), .any_err(any_err),
        .dbuf(dbuf), .cur_ma(cur_ma), .cur_mx(cur_mx), .cur_da(cur_da),
        .cur_dx(cur_dx), .cur_wc(cur_wc)
    );

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
        end
    endtask

    // bench memory and disk models
    logic [15:0] mem_m [int];
    logic [15:0] dsk_m [int];

    function automatic logic [15:0] rd_mem(input logic [17:0] a);
        return mem_m.exists(int'(a >> 1)) ? mem_m[int'(a >> 1)] : 16'h0;
    endfunction
    function automatic logic [15:0] rd_dsk(input logic [21:0] a);
        return dsk_m.exists(int'(a)) ? dsk_m[int'(a)] : 16'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; mem_nxm <= 1'b0; mem_rdata <= 16'h0;
        end else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_nxm   <= (mem_addr >= NXM_LIM);
            mem_rdata <= rd_mem(mem_addr);
            if (mem_we && mem_addr < NXM_LIM) mem_m[int'(mem_addr >> 1)] = mem_wdata;
        end else begin
            mem_ack <= 1'b0; mem_nxm <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) dsk_rdata <= 16'h0;
        else begin
            if (dsk_we) dsk_m[int'(dsk_addr)] = dsk_wdata;
            if (dsk_rd) dsk_rdata <= rd_dsk(dsk_addr);
        end
    end

    // scoreboard
    typedef struct { bit to_dsk; int addr; logic [15:0] data; } item_t;
    item_t expq[$];

    task automatic match(input bit to_dsk, input int addr, input logic [15:0] data);
        item_t e;
        if (expq.size() == 0) begin
            chk(1'b0, to_dsk ? "unexpected disk write addr" : "unexpected mem write addr", addr, -1);
            return;
        end
        e = expq.pop_front();
        chk(e.to_dsk == to_dsk, "write target", to_dsk, e.to_dsk);
        chk(e.addr == addr, "write address", addr, e.addr);
        chk(e.data == data, "write data", data, e.data);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (dsk_we) match(1'b1, int'(dsk_addr), dsk_wdata);
            if (mem_req && mem_we && mem_ack && !mem_nxm) match(1'b0, int'(mem_addr), mem_wdata);
        end
    end

    // reference model results
    logic [17:0] e_ma;
    logic [21:0] e_da;
    logic [15:0] e_wc, e_dbr;
    logic [3:0]  e_err; // {lock, cmp, nodisk, nomem}

    task automatic ref_run(input logic [1:0] fn, input logic [17:0] ma0, input logic [21:0] da0,
                           input logic [15:0] wc0, input logic [15:0] dbr0);
        logic [17:0] ma = ma0 & 18'h3FFFE;
        logic [21:0] da = da0;
        logic [15:0] wc = wc0;
        logic [15:0] dbr = dbr0;
        logic [15:0] w;
        int cap = (int'(plat_sel) + 1) * 262144;
        e_err = 4'b0;
        forever begin
            if (int'(da) >= cap) begin e_err[1] = 1'b1; break; end
            if (fn == 2'd1 && lock_mask[da[19:15]]) begin e_err[3] = 1'b1; break; end
            if (fn == 2'd2) begin
                dbr = rd_dsk(da);
                if (ma >= NXM_LIM) begin e_err[0] = 1'b1; break; end
                expq.push_back('{1'b0, int'(ma), dbr});
            end else if (fn == 2'd3) begin
                dbr = rd_dsk(da);
                if (ma >= NXM_LIM) begin e_err[0] = 1'b1; break; end
                if (rd_mem(ma) != dbr) begin e_err[2] = 1'b1; break; end
            end else begin
                if (ma >= NXM_LIM) begin e_err[0] = 1'b1; break; end
                w = rd_mem(ma);
                expq.push_back('{1'b1, int'(da), w});
                dbr = w;
            end
            da = da + 22'd1;
            if (!ma_hold) ma = ma + 18'd2;
            wc = wc + 16'd1;
            if (wc == 16'd0) break;
        end
        e_ma = ma; e_da = da; e_wc = wc; e_dbr = dbr;
    endtask

    task automatic xfer(input string tag, input logic [1:0] fn, input logic [1:0] mx, input logic [15:0] ma,
                        input logic [5:0] dx, input logic [15:0] da, input logic [15:0] wc,
                        input int exp_busy, input bit poke);
        int nb = 0;
        int guard = 0;
        cur_tag = tag;
        ref_run(fn, {mx, ma}, {dx, da}, wc, dbuf);
        @(negedge clk);
        func = fn; init_mx = mx; init_ma = ma; init_dx = dx; init_da = da; init_wc = wc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "busy/done after start", {busy, done}, 2'b10);
        while (!done && guard < 2000) begin
            if (busy) nb++;
            guard++;
            if (poke && nb == 4) begin
                func = 2'd2; init_wc = 16'hFFFF; init_ma = 16'h0000; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(guard < 2000, "transfer finished", guard, 0);
        chk({cur_mx, cur_ma} == e_ma, "memory address", {cur_mx, cur_ma}, e_ma);
        chk({cur_dx, cur_da} == e_da, "disk address", {cur_dx, cur_da}, e_da);
        chk(cur_wc == e_wc, "word count", cur_wc, e_wc);
        chk(dbuf == e_dbr, "data buffer", dbuf, e_dbr);
        chk({err_lock, err_cmp, err_nodisk, err_nomem} == e_err, "error flags",
            {err_lock, err_cmp, err_nodisk, err_nomem}, e_err);
        chk(any_err == (e_err != 4'b0), "any_err", any_err, e_err != 4'b0);
        chk(expq.size() == 0, "missing transactions", expq.size(), 0);
        expq.delete();
        if (exp_busy >= 0) chk(nb == exp_busy, "busy cycles", nb, exp_busy);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            dsk_m[32'h100 + i] = 16'hA000 + 16'(i);
            mem_m[(32'h200 >> 1) + i] = 16'h5000 + 16'(i);
            dsk_m[32'h300 + i] = 16'hC000 + 16'(i);
            mem_m[(32'h600 >> 1) + i] = 16'hC000 + 16'(i);
            mem_m[(32'h700 >> 1) + i] = (i == 1) ? 16'hDEAD : 16'hC000 + 16'(i);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        cur_tag = "R1";
        chk(done == 1'b1 && busy == 1'b0, "reset done/busy", {done, busy}, 2'b10);
        chk(any_err == 1'b0 && cur_wc == 16'h0 && cur_da == 16'h0, "reset regs", cur_wc, 0);
        chk(!mem_req && !dsk_rd && !dsk_we, "reset requests", {mem_req, dsk_rd, dsk_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 start with func 0 ignored
        cur_tag = "R2";
        func = 2'd0; init_wc = 16'hFFF0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0 && cur_wc == 16'h0, "func 0 start", cur_wc, 0);

        // R4 R9 read burst, 4 words at 4 cycles
        xfer("R4_R9 read", 2'd2, 2'd0, 16'h0200, 6'd0, 16'h0100, 16'hFFFC, 16, 1'b0);
        // R5 R9 write burst, 4 words at 3 cycles
        xfer("R5_R9 write", 2'd1, 2'd0, 16'h0200, 6'd0, 16'h0500, 16'hFFFC, 12, 1'b0);
        // R6 compare match
        xfer("R6 compare match", 2'd3, 2'd0, 16'h0600, 6'd0, 16'h0300, 16'hFFFD, 12, 1'b0);
        // R6 R10 compare mismatch on second word
        xfer("R6_R10 compare mismatch", 2'd3, 2'd0, 16'h0700, 6'd0, 16'h0300, 16'hFFFC, 8, 1'b0);
        // R5 R10 locked segment: da 0x8000 is segment 1
        lock_mask = 32'h0000_0002;
        xfer("R5_R10 locked segment", 2'd1, 2'd0, 16'h0200, 6'd0, 16'h8000, 16'hFFFE, 1, 1'b0);
        lock_mask = 32'h0;
        // R8 beyond one platter
        xfer("R8 beyond capacity", 2'd2, 2'd0, 16'h0800, 6'd4, 16'h0000, 16'hFFFF, 1, 1'b0);
        plat_sel = 3'd1;
        xfer("R8 within two platters", 2'd2, 2'd0, 16'h0800, 6'd4, 16'h0000, 16'hFFFF, 4, 1'b0);
        plat_sel = 3'd0;
        // R7 memory not present after two words
        xfer("R7 not present", 2'd2, 2'd1, 16'hFFFC, 6'd0, 16'h0100, 16'hFFFC, -1, 1'b0);
        // R3 carries into extensions
        xfer("R3 carry", 2'd2, 2'd0, 16'hFFFE, 6'd0, 16'hFFFF, 16'hFFFE, 8, 1'b0);
        // R3 memory address held
        ma_hold = 1'b1;
        xfer("R3 hold", 2'd1, 2'd0, 16'h0201, 6'd0, 16'h0900, 16'hFFFD, 9, 1'b0);
        ma_hold = 1'b0;
        // R9 R2 spaced words, start while busy ignored
        burst = 1'b0; gap_len = 16'd5;
        xfer("R9_R2 spaced", 2'd1, 2'd0, 16'h0200, 6'd0, 16'h0A00, 16'hFFFD, 19, 1'b1);
        gap_len = 16'd0;
        xfer("R9 zero gap", 2'd1, 2'd0, 16'h0200, 6'd0, 16'h0B00, 16'hFFFE, 7, 1'b0);
        burst = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule